// File: doc/BRIEF.md
# Arithmetic Shifter with Condition Codes

This unit performs one arithmetic shift per request for a 16-bit datapath. The operand is either one 16-bit word or a 32-bit value made from a register pair. A 6-bit signed count selects both the direction and the distance of the shift. The unit returns the shifted value together with the four condition flags: negative, zero, overflow and carry.

Left shifts bring zeros in at bit 0. Right shifts are arithmetic and copy the sign bit into the vacated upper bits. Carry holds the last bit that left the operand. On a left shift, overflow is raised when any bit that travels through the sign position differs from the original sign, so it does not depend only on the final sign bit.

Requests arrive with a valid strobe. The result and the flags are registered and appear one cycle later, together with a one-cycle valid strobe.

Top module: `ash_unit`

## Requirements
- R1: `count_i` is a 6-bit two's-complement count. A value of 0 means no shift. Values 1 to 31 shift left by the count. Values 32 to 63 shift right by 64 minus the count, so 63 shifts right by 1 and 32 shifts right by 32.
- R2: A zero count returns the operand unchanged, clears V and C, and sets N and Z from the operand.
- R3: A right shift fills the vacated upper bits with the original sign. This holds up to a shift of 32, so a 16-bit right shift by 32 gives all sign bits and C equal to the sign.
- R4: On a right shift, C equals operand bit (amount − 1) and V is 0.
- R5: On a left shift, zeros enter at bit 0. C equals operand bit (width − amount) when that position exists and 0 otherwise, so the result is zero once the amount reaches the width.
- R6: On a left shift, V is 1 exactly when some bit that passes through or ends in the sign position differs from the original sign bit.
- R7: N equals the sign bit of the truncated result (bit 15 or bit 31). Z is 1 when the truncated result is all zeros.
- R8: When `size_i` is 0, the unit works on `operand_i[15:0]`, ignores `operand_i[31:16]` and drives `result_o[31:16]` to zero. When `size_i` is 1, it works on all 32 bits with the sign at bit 31.
- R9: The result and the flags appear on the cycle after `valid_i` is high, with `valid_o` high for exactly that one cycle. The outputs hold their values while no request arrives. Reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| size_i | input | 1 | 0: 16-bit operand, 1: 32-bit operand |
| operand_i | input | 32 | Value to shift |
| count_i | input | 6 | Signed shift count |
| valid_o | output | 1 | Result strobe, one cycle per request |
| result_o | output | 32 | Shifted value |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |
| flag_v_o | output | 1 | Overflow flag |
| flag_c_o | output | 1 | Carry flag |

## Verification
The bench builds the unit with its default parameters: a 16-bit word and a 6-bit count. With these defaults, every count code can be swept for both operand sizes. The sweep includes left shifts longer than the 16-bit width and the 32-place right shift of a 16-bit word, where the sign fill has to reach past the operand. Directed cases pin the carry and overflow corners, and a bit-serial model in the bench checks the full sweep.

// File: rtl/ash_pkg.sv
package ash_pkg;
  typedef enum logic [1:0] {
    SH_NONE  = 2'd0,
    SH_LEFT  = 2'd1,
    SH_RIGHT = 2'd2
  } sh_dir_e;
endpackage

// File: rtl/ash_count_dec.sv
module ash_count_dec
  import ash_pkg::*;
#(
  parameter int CW = 6
) (
  input  logic [CW-1:0] count_i,
  output sh_dir_e       dir_o,
  output logic [CW-1:0] amt_o
);
  // msb set: right shift by the magnitude of the negative count
  always_comb begin
    if (count_i == '0) begin
      dir_o = SH_NONE;
      amt_o = '0;
    end else if (count_i[CW-1]) begin
      dir_o = SH_RIGHT;
      amt_o = CW'(0) - count_i;
    end else begin
      dir_o = SH_LEFT;
      amt_o = count_i;
    end
  end
endmodule

// File: rtl/ash_left.sv
module ash_left #(
  parameter int W  = 16,
  parameter int CW = 6,
  localparam int DW = 2 * W,
  localparam int XW = 2 * DW
) (
  input  logic [DW-1:0] op_i,
  input  logic [CW-1:0] amt_i,
  input  logic          wide_i,
  output logic [DW-1:0] res_o,
  output logic          c_o,
  output logic          v_o
);
  logic [XW-1:0] ext;
  logic          sign;
  int            spos;

  assign ext  = {{DW{1'b0}}, op_i} << amt_i;
  assign sign = wide_i ? op_i[DW-1] : op_i[W-1];
  assign spos = wide_i ? DW - 1 : W - 1;

  assign res_o = wide_i ? ext[DW-1:0] : {{(DW-W){1'b0}}, ext[W-1:0]};
  assign c_o   = wide_i ? ext[DW] : ext[W];

  // every bit from the sign slot up to sign+amt passed through the sign slot
  always_comb begin
    v_o = 1'b0;
    for (int i = 0; i < XW; i++) begin
      if (i >= spos && i <= spos + int'(amt_i) && ext[i] != sign) v_o = 1'b1;
    end
  end
endmodule

// File: rtl/ash_right.sv
module ash_right #(
  parameter int W  = 16,
  parameter int CW = 6,
  localparam int DW = 2 * W
) (
  input  logic [DW-1:0] op_i,
  input  logic [CW-1:0] amt_i,
  input  logic          wide_i,
  output logic [DW-1:0] res_o,
  output logic          c_o
);
  logic signed [DW:0] sext;
  logic        [DW:0] pre;
  logic        [CW-1:0] amt_m1;

  assign sext   = wide_i ? {op_i[DW-1], op_i} : {{(DW+1-W){op_i[W-1]}}, op_i[W-1:0]};
  assign amt_m1 = (amt_i == '0) ? '0 : amt_i - 1'b1;
  // stop one short so bit 0 holds the last bit shifted out
  assign pre    = sext >>> amt_m1;

  assign c_o   = (amt_i == '0) ? 1'b0 : pre[0];
  assign res_o = wide_i ? pre[DW:1] : {{(DW-W){1'b0}}, pre[W:1]};
endmodule

// File: rtl/ash_unit.sv
module ash_unit
  import ash_pkg::*;
#(
  parameter int W  = 16,
  parameter int CW = 6,
  localparam int DW = 2 * W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          size_i,
  input  logic [DW-1:0] operand_i,
  input  logic [CW-1:0] count_i,
  output logic          valid_o,
  output logic [DW-1:0] result_o,
  output logic          flag_n_o,
  output logic          flag_z_o,
  output logic          flag_v_o,
  output logic          flag_c_o
);
  sh_dir_e       dir;
  logic [CW-1:0] amt;
  logic [DW-1:0] op_m, l_res, r_res, res;
  logic          l_c, l_v, r_c, c, v, n, z;

  assign op_m = size_i ? operand_i : {{(DW-W){1'b0}}, operand_i[W-1:0]};

  ash_count_dec #(.CW(CW)) u_dec (.count_i(count_i), .dir_o(dir), .amt_o(amt));

  ash_left #(.W(W), .CW(CW)) u_left (
    .op_i(op_m), .amt_i(amt), .wide_i(size_i),
    .res_o(l_res), .c_o(l_c), .v_o(l_v)
  );

  ash_right #(.W(W), .CW(CW)) u_right (
    .op_i(op_m), .amt_i(amt), .wide_i(size_i),
    .res_o(r_res), .c_o(r_c)
  );

  always_comb begin
    unique case (dir)
      SH_LEFT:  begin res = l_res; c = l_c; v = l_v;  end
      SH_RIGHT: begin res = r_res; c = r_c; v = 1'b0; end
      default:  begin res = op_m;  c = 1'b0; v = 1'b0; end
    endcase
  end

  assign n = size_i ? res[DW-1] : res[W-1];
  assign z = (res == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
      flag_n_o <= 1'b0;
      flag_z_o <= 1'b0;
      flag_v_o <= 1'b0;
      flag_c_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o <= res;
        flag_n_o <= n;
        flag_z_o <= z;
        flag_v_o <= v;
        flag_c_o <= c;
      end
    end
  end

  assert_valid_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i));

  assert_hold_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o));

  assert_right_no_v_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && count_i[CW-1] |=> !flag_v_o);

  assert_zero_count_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && count_i == '0 |=> !flag_v_o && !flag_c_o);

  assert_narrow_upper_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !size_i |=> result_o[DW-1:W] == '0);
endmodule

// File: tb/ash_unit_bench.sv
module ash_unit_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic        size_i = 1'b0;
  logic [31:0] operand_i = '0;
  logic [5:0]  count_i = '0;
  logic        valid_o;
  logic [31:0] result_o;
  logic        flag_n_o, flag_z_o, flag_v_o, flag_c_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  ash_unit u_ash_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .size_i(size_i),
    .operand_i(operand_i), .count_i(count_i), .valid_o(valid_o),
    .result_o(result_o), .flag_n_o(flag_n_o), .flag_z_o(flag_z_o),
    .flag_v_o(flag_v_o), .flag_c_o(flag_c_o)
  );

  // {result, n, z, v, c}
  function automatic logic [35:0] model(logic [31:0] op, logic [5:0] cnt, logic sz);
    int w = sz ? 32 : 16;
    logic [31:0] x = sz ? op : {16'h0, op[15:0]};
    logic s = x[w-1];
    logic c = 1'b0, ov = 1'b0;
    if (cnt != 0 && !cnt[5]) begin
      for (int k = 0; k < int'(cnt); k++) begin
        c = x[w-1];
        x = x << 1;
        if (!sz) x[31:16] = '0;
        if (x[w-1] != s) ov = 1'b1;
      end
    end else if (cnt[5]) begin
      for (int k = 0; k < 64 - int'(cnt); k++) begin
        c = x[0];
        x = x >> 1;
        x[w-1] = s;
      end
    end
    return {x, x[w-1], x == 0, ov, c};
  endfunction

  task automatic check(string req, logic [35:0] got, logic [35:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [35:0] outs();
    return {result_o, flag_n_o, flag_z_o, flag_v_o, flag_c_o};
  endfunction

  task automatic issue(logic [31:0] op, logic [5:0] cnt, logic sz);
    @(negedge clk_i);
    valid_i = 1'b1; operand_i = op; count_i = cnt; size_i = sz;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  task automatic shot(string req, logic [31:0] op, logic [5:0] cnt, logic sz,
                      logic [31:0] r, logic n, logic z, logic v, logic c);
    issue(op, cnt, sz);
    check({req, " valid"}, {35'h0, valid_o}, 36'h1);
    check(req, outs(), {r, n, z, v, c});
  endtask

  task automatic t_reset();
    check("R9 reset", {outs()[35:0]} | {35'h0, valid_o}, 36'h0);
  endtask

  task automatic t_zero_count();
    shot("R2 zero count neg", 32'h0000_8000, 6'd0, 1'b0, 32'h8000, 1, 0, 0, 0);
    shot("R2 zero count zero", 32'hABCD_0000, 6'd0, 1'b0, 32'h0, 0, 1, 0, 0);
  endtask

  task automatic t_left();
    shot("R6 left1 sign change", 32'h4000, 6'd1, 1'b0, 32'h8000, 1, 0, 1, 0);
    shot("R5 left1 keep sign", 32'hC000, 6'd1, 1'b0, 32'h8000, 1, 0, 0, 1);
    shot("R6 left2 inner diff", 32'hC000, 6'd2, 1'b0, 32'h0, 0, 1, 1, 1);
    shot("R5 left16 width", 32'h0001, 6'd16, 1'b0, 32'h0, 0, 1, 1, 1);
    shot("R5 left17 beyond", 32'h0001, 6'd17, 1'b0, 32'h0, 0, 1, 1, 0);
    shot("R6 left32b", 32'h4000_0000, 6'd1, 1'b1, 32'h8000_0000, 1, 0, 1, 0);
  endtask

  task automatic t_right();
    shot("R4 right1", 32'h8001, 6'd63, 1'b0, 32'hC000, 1, 0, 0, 1);
    shot("R3 right32 narrow neg", 32'h8000, 6'd32, 1'b0, 32'hFFFF, 1, 0, 0, 1);
    shot("R3 right32 narrow pos", 32'h7FFF, 6'd32, 1'b0, 32'h0, 0, 1, 0, 0);
    shot("R3 right32 wide", 32'h8000_0000, 6'd32, 1'b1, 32'hFFFF_FFFF, 1, 0, 0, 1);
    shot("R1 right1 wide", 32'h0000_0003, 6'd63, 1'b1, 32'h1, 0, 0, 0, 1);
  endtask

  task automatic t_narrow_ignore();
    shot("R8 upper ignored", 32'hFFFF_0001, 6'd1, 1'b0, 32'h0002, 0, 0, 0, 0);
  endtask

  task automatic t_hold();
    logic [35:0] prev;
    issue(32'h1234, 6'd3, 1'b0);
    prev = outs();
    @(negedge clk_i);
    check("R9 valid one cycle", {35'h0, valid_o}, 36'h0);
    operand_i = 32'hFFFF_FFFF; count_i = 6'd5;
    repeat (3) @(negedge clk_i);
    check("R9 hold idle", outs(), prev);
  endtask

  task automatic t_sweep();
    logic [31:0] lf = 32'hACE1_2357;
    for (int sz = 0; sz < 2; sz++) begin
      for (int cnt = 0; cnt < 64; cnt++) begin
        for (int p = 0; p < 6; p++) begin
          logic [31:0] op;
          lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
          op = (p == 0) ? 32'h0 : (p == 1) ? 32'hFFFF_FFFF : (p == 2) ? 32'h8000_8000 : lf;
          issue(op, 6'(cnt), sz[0]);
          check("R1 R3 R4 R5 R6 R7 R8 sweep", outs(), model(op, 6'(cnt), sz[0]));
        end
      end
    end
  endtask

  initial begin
    #100000000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_zero_count();
    t_left();
    t_right();
    t_narrow_ignore();
    t_hold();
    t_sweep();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule